// File: doc/BRIEF.md
# System Address Decoder with Boot ROM Overlay

This block sits between a 24-bit CPU bus and the memories and peripherals of a small system. Each cycle that `acc_valid` is high it turns the CPU address into one-hot selects: a region (ROM, RAM, a lower I/O zone, an upper control zone) and, inside the I/O zones, the individual register, expansion slot, sub-device or control bit being addressed. It also raises a flag when a read must return all ones, and another when a write must be discarded.

After reset a boot overlay is active. It sets address bit 23 on every access, so the CPU fetches its reset vectors and early code from ROM whatever address it issues. Software ends the overlay by writing a one to a write-only release bit in the control zone. A second write-only bit in the same place enables parity interrupts. Both bits are visible as output pins for the rest of the chip.

Decoding is purely combinational on the same cycle. There is no back-pressure: the strobe is a qualifier, not a handshake. Only the two control bits are registered, and they change on the clock edge that ends the write.

Top module: `sys_addr_decode`

## Requirements
- R1: After reset, `rom_map_rel` and `parity_ie` are both 0.
- R2: While `rom_map_rel` is 0, `eff_addr` equals `cpu_addr` with bit 23 forced to 1. Once it is 1, `eff_addr` equals `cpu_addr`. All decoding below uses `eff_addr`.
- R3: `region_sel` is one-hot and asserted only while `acc_valid` is high. Bit 0 means ROM (0x800000–0xBFFFFF), bit 1 means RAM (below 0x400000), bit 2 means I/O zone A (0x400000–0x7FFFFF) and bit 3 means control zone B (0xC00000–0xFFFFFF). With `acc_valid` low, all selects and both flags are 0.
- R4: A RAM-region address at or above the `RAM_BYTES` parameter is undecoded. A read there raises `rd_ones` and a write raises `wr_drop`.
- R5: In zone A, address bits 19:16 drive `zonea_sel`: code 0 gives bit 0 (map RAM), 1 gives bit 1 (general status), 2 gives bit 2 (video RAM), 3 gives bit 3 (bus status 0), 4 gives bit 4 (bus status 1) and 0xC gives bit 5 (clear status). Any other code is undecoded, as in R4.
- R6: When bits 23:20 are 0xC or 0xD, `slot_sel` bit n is set, where n is the value of bits 20:18. Each slot is a 256 KB window.
- R7: When bits 23:20 are 0xE or 0xF, `sub_sel` bit n is set, where n is the value of bits 18:16.
- R8: When sub-device 4 is selected, `ctl_sel` bit n is set, where n is the value of bits 14:12. Bit 1 is the parity interrupt enable and bit 3 is the overlay release.
- R9: A word write (`acc_size`=1) or long write (`acc_size`=2) to control bit 1 or 3 loads `wr_data[15]` into `parity_ie` or `rom_map_rel` at the next clock edge.
- R10: A byte write (`acc_size`=0) to control bit 1 or 3 loads `wr_data[7]`, and only if address bit 0 is 0. A byte write to an odd address leaves both bits unchanged.
- R11: A read of any control-bit location raises `rd_ones` and changes neither control bit.
- R12: A write into the ROM region raises `wr_drop`. A read of ROM raises neither flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | A bus access is present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0 byte, 1 word, 2 long |
| cpu_addr | input | 24 | CPU byte address |
| wr_data | input | 16 | Write data, low word of a long |
| eff_addr | output | 24 | Address after the boot overlay |
| region_sel | output | 4 | One-hot region select |
| zonea_sel | output | 6 | One-hot zone A register select |
| slot_sel | output | 8 | One-hot expansion slot select |
| sub_sel | output | 8 | One-hot zone B sub-device select |
| ctl_sel | output | 8 | One-hot control bit select |
| rd_ones | output | 1 | The read must return all ones |
| wr_drop | output | 1 | The write must be discarded |
| rom_map_rel | output | 1 | Boot overlay released |
| parity_ie | output | 1 | Parity interrupt enable |

## Verification
The decode is swept over every 4 KB page of the address space, with a varying even offset inside each page. The sweep runs once as reads with the overlay active, which shows that every address collapses into the upper half of the map. It then runs as reads and as writes with the overlay released, which separates the region boundaries, the RAM size limit, the unused zone A codes and the direction-dependent flags. Separate directed writes vary the access size, the address parity and which of data bits 15 and 7 is set. This shows that each control bit takes its value from the correct lane and that odd byte writes and reads leave both bits alone.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;
  localparam int NREG   = 4;
  localparam int NZA    = 6;
  localparam int NSEL8  = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } acc_size_e;

  // zone A register codes on address bits 19:16, index = zonea_sel bit
  localparam logic [3:0] ZA_CODES [NZA] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'hC};

  localparam logic [2:0] CTL_SUBDEV  = 3'd4;
  localparam int         CTL_PIE_BIT = 1;
  localparam int         CTL_REL_BIT = 3;
endpackage

// File: rtl/sad_overlay.sv
module sad_overlay
  import sad_pkg::*;
(
  input  logic              released,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  localparam logic [ADDR_W-1:0] FORCE_MASK = 1 << (ADDR_W - 1);

  always_comb begin
    addr_out = released ? addr_in : (addr_in | FORCE_MASK);
  end
endmodule

// File: rtl/sad_region.sv
module sad_region
  import sad_pkg::*;
#(
  parameter int RAM_BYTES = 32'h0020_0000
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] eff,
  output logic [NREG-1:0]   region_sel,
  output logic [NZA-1:0]    zonea_sel,
  output logic              undecoded
);
  localparam logic [31:0] RAM_LIM = RAM_BYTES;

  logic in_rom, in_ram, in_za, in_zb, ram_fits;
  logic [31:0] eff_ext;

  always_comb begin
    eff_ext  = {{(32-ADDR_W){1'b0}}, eff};
    in_ram   = valid && (eff[ADDR_W-1:ADDR_W-2] == 2'b00);
    in_za    = valid && (eff[ADDR_W-1:ADDR_W-2] == 2'b01);
    in_rom   = valid && (eff[ADDR_W-1:ADDR_W-2] == 2'b10);
    in_zb    = valid && (eff[ADDR_W-1:ADDR_W-2] == 2'b11);
    ram_fits = eff_ext < RAM_LIM;
    region_sel = {in_zb, in_za, in_ram, in_rom};
  end

  for (genvar i = 0; i < NZA; i++) begin : g_za
    assign zonea_sel[i] = in_za && (eff[19:16] == ZA_CODES[i]);
  end

  assign undecoded = (in_ram && !ram_fits) || (in_za && (zonea_sel == '0));
endmodule

// File: rtl/sad_zoneb.sv
module sad_zoneb
  import sad_pkg::*;
(
  input  logic              valid,
  input  logic [ADDR_W-1:0] eff,
  output logic [NSEL8-1:0]  slot_sel,
  output logic [NSEL8-1:0]  sub_sel,
  output logic [NSEL8-1:0]  ctl_sel
);
  logic slot_zone, dev_zone, ctl_zone;

  assign slot_zone = valid && (eff[23:21] == 3'b110);
  assign dev_zone  = valid && (eff[23:21] == 3'b111);
  assign ctl_zone  = dev_zone && (eff[18:16] == CTL_SUBDEV);

  for (genvar i = 0; i < NSEL8; i++) begin : g_sel
    assign slot_sel[i] = slot_zone && (eff[20:18] == 3'(i));
    assign sub_sel[i]  = dev_zone  && (eff[18:16] == 3'(i));
    assign ctl_sel[i]  = ctl_zone  && (eff[14:12] == 3'(i));
  end
endmodule

// File: rtl/sad_ctl_regs.sv
module sad_ctl_regs
  import sad_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [1:0]        size,
  input  logic              addr_lsb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NSEL8-1:0]  ctl_sel,
  output logic              rel_q,
  output logic              pie_q
);
  logic is_byte, lane_ok, new_val;

  always_comb begin
    is_byte = (acc_size_e'(size) == SZ_BYTE);
    lane_ok = !is_byte || !addr_lsb;
    new_val = is_byte ? wdata[7] : wdata[DATA_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q <= 1'b0;
      pie_q <= 1'b0;
    end else if (wr_stb && lane_ok) begin
      if (ctl_sel[CTL_REL_BIT]) rel_q <= new_val;
      if (ctl_sel[CTL_PIE_BIT]) pie_q <= new_val;
    end
  end
endmodule

// File: rtl/sys_addr_decode.sv
module sys_addr_decode
  import sad_pkg::*;
#(
  parameter int RAM_BYTES = 32'h0020_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [1:0]        acc_size,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [NREG-1:0]   region_sel,
  output logic [NZA-1:0]    zonea_sel,
  output logic [NSEL8-1:0]  slot_sel,
  output logic [NSEL8-1:0]  sub_sel,
  output logic [NSEL8-1:0]  ctl_sel,
  output logic              rd_ones,
  output logic              wr_drop,
  output logic              rom_map_rel,
  output logic              parity_ie
);
  logic undec;

  sad_overlay u_ovl (
    .released (rom_map_rel),
    .addr_in  (cpu_addr),
    .addr_out (eff_addr)
  );

  sad_region #(.RAM_BYTES(RAM_BYTES)) u_reg (
    .valid      (acc_valid),
    .eff        (eff_addr),
    .region_sel (region_sel),
    .zonea_sel  (zonea_sel),
    .undecoded  (undec)
  );

  sad_zoneb u_zb (
    .valid    (acc_valid),
    .eff      (eff_addr),
    .slot_sel (slot_sel),
    .sub_sel  (sub_sel),
    .ctl_sel  (ctl_sel)
  );

  sad_ctl_regs u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (acc_valid && acc_write),
    .size     (acc_size),
    .addr_lsb (eff_addr[0]),
    .wdata    (wr_data),
    .ctl_sel  (ctl_sel),
    .rel_q    (rom_map_rel),
    .pie_q    (parity_ie)
  );

  assign rd_ones = acc_valid && !acc_write && (undec || (ctl_sel != '0));
  assign wr_drop = acc_valid &&  acc_write && (undec || region_sel[0]);
endmodule

// File: rtl/sad_chk.sv
module sad_chk
  import sad_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [1:0]        acc_size,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [ADDR_W-1:0] eff_addr,
  input logic [NREG-1:0]   region_sel,
  input logic [NSEL8-1:0]  sub_sel,
  input logic [NSEL8-1:0]  ctl_sel,
  input logic              rd_ones,
  input logic              wr_drop,
  input logic              rom_map_rel,
  input logic              parity_ie
);
  // R2
  overlay_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_map_rel |-> eff_addr[ADDR_W-1]);

  // R3
  region_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(region_sel));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (region_sel == '0 && !rd_ones && !wr_drop));

  // R8
  ctl_in_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_sel != '0) |-> sub_sel[CTL_SUBDEV]);

  // R11
  no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_write) |=> ($stable(rom_map_rel) && $stable(parity_ie)));

  // R10
  odd_byte_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_size == 2'd0 && cpu_addr[0])
      |=> ($stable(rom_map_rel) && $stable(parity_ie)));

  // R12
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_ones && wr_drop));
endmodule

bind sys_addr_decode sad_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .acc_write   (acc_write),
  .acc_size    (acc_size),
  .cpu_addr    (cpu_addr),
  .eff_addr    (eff_addr),
  .region_sel  (region_sel),
  .sub_sel     (sub_sel),
  .ctl_sel     (ctl_sel),
  .rd_ones     (rd_ones),
  .wr_drop     (wr_drop),
  .rom_map_rel (rom_map_rel),
  .parity_ie   (parity_ie)
);

// File: tb/sim_sys_addr_decode.sv
module sim_sys_addr_decode;
  localparam int RAMB = 32'h0010_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [1:0]  acc_size = 2'd1;
  logic [23:0] cpu_addr = '0;
  logic [15:0] wr_data = '0;
  logic [23:0] eff_addr;
  logic [3:0]  region_sel;
  logic [5:0]  zonea_sel;
  logic [7:0]  slot_sel, sub_sel, ctl_sel;
  logic        rd_ones, wr_drop, rom_map_rel, parity_ie;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sys_addr_decode #(.RAM_BYTES(RAMB)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_size(acc_size), .cpu_addr(cpu_addr), .wr_data(wr_data),
    .eff_addr(eff_addr), .region_sel(region_sel), .zonea_sel(zonea_sel),
    .slot_sel(slot_sel), .sub_sel(sub_sel), .ctl_sel(ctl_sel),
    .rd_ones(rd_ones), .wr_drop(wr_drop), .rom_map_rel(rom_map_rel),
    .parity_ie(parity_ie));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected {eff, region, zonea, slot, sub, ctl, rd_ones, wr_drop}
  function automatic logic [63:0] model(input int a, input bit wr, input bit ovl);
    int e, nib, code;
    logic [3:0] reg_e;
    logic [5:0] za;
    logic [7:0] sl, sb, ct;
    bit undec, rdo, wdr;
    e = ovl ? (a | 32'h80_0000) : a;
    nib = e / 32'h10_0000;
    code = (e / 32'h1_0000) % 16;
    reg_e = '0; za = '0; sl = '0; sb = '0; ct = '0;
    if (e < 32'h40_0000) reg_e = 4'b0010;
    else if (e < 32'h80_0000) reg_e = 4'b0100;
    else if (e < 32'hC0_0000) reg_e = 4'b0001;
    else reg_e = 4'b1000;
    if (reg_e == 4'b0100) begin
      if (code <= 4) za = 6'(1 << code);
      else if (code == 12) za = 6'b100000;
    end
    if (nib == 12 || nib == 13) sl = 8'(1 << ((e / 32'h4_0000) % 8));
    if (nib == 14 || nib == 15) sb = 8'(1 << code % 8);
    if (sb == 8'h10) ct = 8'(1 << ((e / 4096) % 8));
    undec = (reg_e == 4'b0010 && e >= RAMB) || (reg_e == 4'b0100 && za == 0);
    rdo = !wr && (undec || ct != 0);
    wdr = wr && (undec || reg_e == 4'b0001);
    return {4'd0, 24'(e), reg_e, za, sl, sb, ct, rdo, wdr};
  endfunction

  function automatic logic [63:0] actual();
    return {4'd0, eff_addr, region_sel, zonea_sel, slot_sel, sub_sel, ctl_sel, rd_ones, wr_drop};
  endfunction

  task automatic sweep(input bit wr, input bit ovl, input string tag);
    for (int p = 0; p < 4096; p++) begin
      int a;
      @(negedge clk);
      a = p * 4096 + (((p * 37) % 4096) & 32'hFFE);
      acc_valid = 1'b1; acc_write = wr; acc_size = 2'd1;
      wr_data = 16'h8080; cpu_addr = 24'(a);
      #1;
      check(tag, actual(), model(a, wr, ovl));
    end
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic do_write(input logic [23:0] a, input logic [1:0] sz, input logic [15:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_size = sz; cpu_addr = a; wr_data = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    #1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    check("R1", {62'd0, rom_map_rel, parity_ie}, 64'd0);
    // R3 idle: no selects, no flags
    cpu_addr = 24'hE43000; #1;
    check("R3 idle", {28'd0, region_sel, sub_sel, ctl_sel, rd_ones, wr_drop}, 64'd0);

    // R2 overlay active: every address forced into the upper half
    sweep(1'b0, 1'b1, "R2 overlay read");

    // R11 read of control location
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; cpu_addr = 24'h643000; #1;
    check("R11 rd_ones", {63'd0, rd_ones}, 64'd1);
    @(negedge clk); acc_valid = 1'b0; #1;
    check("R11 bits kept", {62'd0, rom_map_rel, parity_ie}, 64'd0);

    // R10 odd byte write ignored
    do_write(24'hE43001, 2'd0, 16'h00FF);
    check("R10 odd byte", {62'd0, rom_map_rel, parity_ie}, 64'd0);
    // R10 byte uses bit 7, not bit 15
    do_write(24'hE43000, 2'd0, 16'hFF00);
    check("R10 byte lane", {63'd0, rom_map_rel}, 64'd0);
    // R9 word write takes bit 15
    do_write(24'hE41000, 2'd1, 16'h8000);
    check("R9 word set", {63'd0, parity_ie}, 64'd1);
    // R9 long write ignores bit 7
    do_write(24'hE41000, 2'd2, 16'h0080);
    check("R9 long clear", {63'd0, parity_ie}, 64'd0);
    // R10 even byte write with bit 7 releases overlay
    do_write(24'hE43000, 2'd0, 16'h0080);
    check("R10 even byte", {62'd0, rom_map_rel, parity_ie}, 64'd2);

    // released: full decode, reads then writes (R4 R5 R6 R7 R8 R12)
    sweep(1'b0, 1'b0, "R3/R4/R5/R6/R7/R8/R12 read");
    sweep(1'b1, 1'b0, "R3/R4/R5/R12 write");
    #1;
    check("R9 release held", {63'd0, rom_map_rel}, 64'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule